// File: doc/BRIEF.md
# Multicart Outer-Bank Memory Mapper

This block turns CPU and video-bus addresses into banked memory addresses for a cartridge that carries several games. An inner swappable-bank mapper keeps a bank-select register, eight bank data registers and a mirroring register. Three outer registers then narrow and shift the inner bank numbers, so that each game sees only its own region of a large ROM set. Each bank number also yields a 4-bit chip select.

Software programs the registers through a CPU write port made of address, data and a write strobe. The PRG bank number, its chip select, the CHR bank number and its chip select, a CHR-RAM select and the mirroring control are all combinational functions of the register state and of the current CPU and video addresses. One outer mode bit sends every CHR access to an internal 8 KB RAM.

Top module: `multicart_bank_mapper`

## Requirements
- R1: A write with wrAddr[15:14]=2'b10 is decoded only on wrAddr[13] and wrAddr[0]. {0,0} writes bank select, {0,1} writes bank data, {1,0} writes mirroring, and {1,1} has no effect. All other address bits are ignored.
- R2: A bank-data write stores wrData into bank register number bankSel[2:0].
- R3: The PRG inner bank for cpuAddr[14:13] is chosen as follows. Window 1 uses register 7. Window 3 uses 0xFF. When bankSel[6]=0, window 0 uses register 6 and window 2 uses 0xFE. When bankSel[6]=1, those two are exchanged.
- R4: prgBank (10 bits) = (inner AND mask) OR (prgOuter×2). The mask comes from sizeMode[2:0]: 0→63, 1→31, 2→15, 3→1, 4→3, and 5 to 7→0. prgChip = prgBank[9:6].
- R5: The CHR window index is {ppuAddr[12] XOR bankSel[7], ppuAddr[11:10]}. Indices 0–3 form two 2 KB windows: index[1] picks register 0 or register 1, with bit 0 of the register replaced by ppuAddr[10]. Indices 4–7 use registers 2–5, one register per 1 KB window.
- R6: With sizeMode[5]=0, chrBank (13 bits, in 1 KB units) = inner 1 KB number OR (chrOuter×8), and chrChip = chrBank[12:9].
- R7: With sizeMode[5]=1, chrRamSel=1, chrChip=0 and chrBank = inner 1 KB number mod 8. With sizeMode[5]=0, chrRamSel=0.
- R8: mirror equals the inverse of bit 0 of the last mirroring write.
- R9: Writes to exactly 0x5FF0, 0x5FF1 and 0x5FF2 load sizeMode, prgOuter and chrOuter respectively. Each takes effect on every window from the next clock.
- R10: After reset: sizeMode=0x24, prgOuter=159, chrOuter=0, bankSel=0, register 6=0, register 7=1, all other bank registers 0, and the mirroring register 0 (so mirror=1).
- R11: Writes to any other address change no output. Outputs follow the current cpuAddr and ppuAddr without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| cpuAddr | input | 16 | CPU read address |
| ppuAddr | input | 13 | Video pattern-space address |
| prgBank | output | 10 | PRG 8 KB bank number |
| prgChip | output | 4 | PRG chip select |
| chrBank | output | 13 | CHR 1 KB bank number |
| chrChip | output | 4 | CHR chip select |
| chrRamSel | output | 1 | CHR goes to internal RAM |
| mirror | output | 1 | Mirroring control |

## Verification
The assertions check, on every cycle, these relations:
- a size-mode write sets chrRamSel from its bit 5 on the next cycle;
- a mirroring write sets mirror to the inverse of its bit 0;
- the outer PRG and CHR offsets appear as set bits in the bank numbers;
- RAM mode forces chip 0 and a 3-bit bank;
- an undecoded write leaves the PRG bank steady.

Only the bench's scenarios show the full arithmetic:
- the PRG window swap and the CHR half inversion;
- each size-mask entry;
- the 2 KB alignment and the reset values.

The bench compares every window against a model after each random write.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef struct packed {
    logic selWr;
    logic dataWr;
    logic mirWr;
    logic sizeWr;
    logic prgOutWr;
    logic chrOutWr;
  } wrStrobes_t;

  function automatic logic [7:0] sizeMask(input logic [2:0] mode);
    case (mode)
      3'd0: sizeMask = 8'd63;
      3'd1: sizeMask = 8'd31;
      3'd2: sizeMask = 8'd15;
      3'd3: sizeMask = 8'd1;
      3'd4: sizeMask = 8'd3;
      default: sizeMask = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/mcm_ctrl.sv
module mcm_ctrl
  import mcm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SIZE_ADDR = 16'h5FF0,
  parameter logic [ADDR_W-1:0] PRG_OUT_ADDR = 16'h5FF1,
  parameter logic [ADDR_W-1:0] CHR_OUT_ADDR = 16'h5FF2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobes_t        strobes
);
  logic innerHit;

  // R1: inner registers decode only on the top two bits, bit 13 and bit 0
  assign innerHit = wrEn && (wrAddr[ADDR_W-1:ADDR_W-2] == 2'b10);

  always_comb begin
    strobes = '0;
    strobes.selWr    = innerHit && !wrAddr[13] && !wrAddr[0];
    strobes.dataWr   = innerHit && !wrAddr[13] &&  wrAddr[0];
    strobes.mirWr    = innerHit &&  wrAddr[13] && !wrAddr[0];
    // R9: outer registers decode on the full address
    strobes.sizeWr   = wrEn && (wrAddr == SIZE_ADDR);
    strobes.prgOutWr = wrEn && (wrAddr == PRG_OUT_ADDR);
    strobes.chrOutWr = wrEn && (wrAddr == CHR_OUT_ADDR);
  end
endmodule

// File: rtl/mcm_datapath.sv
module mcm_datapath
  import mcm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 8,
  parameter int CHIP_W = 4,
  parameter int PRG_CHIP_LSB = 6,
  parameter int CHR_CHIP_LSB = 9,
  parameter logic [DATA_W-1:0] SIZE_RST = 8'h24,
  parameter logic [DATA_W-1:0] PRG_OUT_RST = 8'd159,
  localparam int PRG_BANK_W = PRG_CHIP_LSB + CHIP_W,
  localparam int CHR_BANK_W = CHR_CHIP_LSB + CHIP_W,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  wrStrobes_t            strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [1:0]            prgWin,
  input  logic [12:0]           ppuAddr,
  output logic [PRG_BANK_W-1:0] prgBank,
  output logic [CHIP_W-1:0]     prgChip,
  output logic [CHR_BANK_W-1:0] chrBank,
  output logic [CHIP_W-1:0]     chrChip,
  output logic                  chrRamSel,
  output logic                  mirror
);
  logic [DATA_W-1:0] bankSel, sizeMode, prgOuter, chrOuter;
  logic              mirReg;
  logic [DATA_W-1:0] bankReg [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bankSel  <= '0;
      sizeMode <= SIZE_RST;
      prgOuter <= PRG_OUT_RST;
      chrOuter <= '0;
      mirReg   <= 1'b0;
    end else begin
      if (strobes.selWr)    bankSel  <= wrData;
      if (strobes.sizeWr)   sizeMode <= wrData;
      if (strobes.prgOutWr) prgOuter <= wrData;
      if (strobes.chrOutWr) chrOuter <= wrData;
      if (strobes.mirWr)    mirReg   <= wrData[0];
    end
  end

  // R2, R10: one register per bank slot, register 7 resets to 1
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bankReg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bankReg[i] <= (i == NUM_REGS - 1) ? DATA_W'(1) : '0;
      else if (strobes.dataWr && bankSel[SEL_W-1:0] == SEL_W'(i))
        bankReg[i] <= wrData;
    end
  end

  // R3, R4: PRG window selection, then mask and outer offset
  logic              prgSwap;
  logic [DATA_W-1:0] prgInner;
  logic [PRG_BANK_W-1:0] prgFull;

  assign prgSwap = bankSel[6];

  always_comb begin
    case (prgWin)
      2'd0:    prgInner = prgSwap ? 8'hFE : bankReg[6];
      2'd1:    prgInner = bankReg[7];
      2'd2:    prgInner = prgSwap ? bankReg[6] : 8'hFE;
      default: prgInner = 8'hFF;
    endcase
  end

  assign prgFull = PRG_BANK_W'(prgInner & sizeMask(sizeMode[2:0]))
                 | (PRG_BANK_W'(prgOuter) << 1);
  assign prgBank = prgFull;
  assign prgChip = prgFull[PRG_BANK_W-1:PRG_CHIP_LSB];

  // R5: CHR window selection in 1 KB units
  logic [2:0]        chrWin;
  logic [DATA_W-1:0] chrInner;
  logic [CHR_BANK_W-1:0] chrRom;

  assign chrWin = {ppuAddr[12] ^ bankSel[7], ppuAddr[11:10]};

  always_comb begin
    if (!chrWin[2])
      chrInner = {bankReg[{2'b00, chrWin[1]}][DATA_W-1:1], ppuAddr[10]};
    else
      chrInner = bankReg[{1'b0, chrWin[1:0]} + 3'd2];
  end

  // R6, R7: outer CHR offset, or the internal RAM
  assign chrRom    = CHR_BANK_W'(chrInner) | (CHR_BANK_W'(chrOuter) << 3);
  assign chrRamSel = sizeMode[5];
  assign chrBank   = chrRamSel ? CHR_BANK_W'(chrInner[2:0]) : chrRom;
  assign chrChip   = chrRamSel ? '0 : chrRom[CHR_BANK_W-1:CHR_CHIP_LSB];

  // R8
  assign mirror = ~mirReg;
endmodule

// File: rtl/multicart_bank_mapper.sv
module multicart_bank_mapper
  import mcm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CHIP_W = 4,
  parameter int PRG_CHIP_LSB = 6,
  parameter int CHR_CHIP_LSB = 9,
  localparam int PRG_BANK_W = PRG_CHIP_LSB + CHIP_W,
  localparam int CHR_BANK_W = CHR_CHIP_LSB + CHIP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [12:0]           ppuAddr,
  output logic [PRG_BANK_W-1:0] prgBank,
  output logic [CHIP_W-1:0]     prgChip,
  output logic [CHR_BANK_W-1:0] chrBank,
  output logic [CHIP_W-1:0]     chrChip,
  output logic                  chrRamSel,
  output logic                  mirror
);
  wrStrobes_t strobes;

  mcm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes)
  );

  mcm_datapath #(
    .DATA_W(DATA_W), .CHIP_W(CHIP_W),
    .PRG_CHIP_LSB(PRG_CHIP_LSB), .CHR_CHIP_LSB(CHR_CHIP_LSB)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .prgWin(cpuAddr[14:13]), .ppuAddr(ppuAddr),
    .prgBank(prgBank), .prgChip(prgChip), .chrBank(chrBank),
    .chrChip(chrChip), .chrRamSel(chrRamSel), .mirror(mirror)
  );
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic [15:0] wrAddr,
  input logic [7:0]  wrData,
  input logic [15:0] cpuAddr,
  input logic [12:0] ppuAddr,
  input logic [9:0]  prgBank,
  input logic [3:0]  prgChip,
  input logic [12:0] chrBank,
  input logic [3:0]  chrChip,
  input logic        chrRamSel,
  input logic        mirror
);
  logic pastOk;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pastOk <= 1'b0;
    else        pastOk <= 1'b1;

  logic wrSize, wrPrgOut, wrChrOut, wrMir, wrDecoded;
  assign wrSize   = wrEn && wrAddr == 16'h5FF0;
  assign wrPrgOut = wrEn && wrAddr == 16'h5FF1;
  assign wrChrOut = wrEn && wrAddr == 16'h5FF2;
  assign wrMir    = wrEn && wrAddr[15:14] == 2'b10 && wrAddr[13] && !wrAddr[0];
  assign wrDecoded = wrSize || wrPrgOut || wrChrOut ||
                     (wrAddr[15:14] == 2'b10 && !(wrAddr[13] && wrAddr[0]));

  assert_ram_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && $past(wrSize) |-> chrRamSel == $past(wrData[5]));

  assert_ram_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chrRamSel |-> (chrChip == 4'd0 && chrBank < 13'd8));

  assert_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && $past(wrMir) |-> mirror == !$past(wrData[0]));

  assert_prg_outer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && $past(wrPrgOut) |->
      ((prgBank & {1'b0, $past(wrData), 1'b0}) == {1'b0, $past(wrData), 1'b0}));

  assert_chr_outer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && $past(wrChrOut) && !chrRamSel |->
      ((chrBank & {2'b00, $past(wrData), 3'b000}) == {2'b00, $past(wrData), 3'b000}));

  assert_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pastOk && $past(wrEn && !wrDecoded) && $stable(cpuAddr) |-> $stable(prgBank));
endmodule

bind multicart_bank_mapper mcm_checker u_chk (.*);

// File: tb/multicart_bank_mapper_tb.sv
module multicart_bank_mapper_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wrEn = 0;
  logic [15:0] wrAddr = 0;
  logic [7:0]  wrData = 0;
  logic [15:0] cpuAddr = 16'h8000;
  logic [12:0] ppuAddr = 0;
  logic [9:0]  prgBank;
  logic [3:0]  prgChip;
  logic [12:0] chrBank;
  logic [3:0]  chrChip;
  logic        chrRamSel, mirror;

  int total = 0, bad = 0;

  logic [7:0] mSel, mSize, mPrgO, mChrO;
  logic       mMir;
  logic [7:0] mReg [8];

  always #10 clk = ~clk;

  multicart_bank_mapper u_dut (.*);

  function automatic logic [7:0] expMask(input logic [2:0] s);
    case (s)
      3'd0: return 8'd63;   3'd1: return 8'd31;
      3'd2: return 8'd15;   3'd3: return 8'd1;
      3'd4: return 8'd3;    default: return 8'd0;
    endcase
  endfunction

  function automatic logic [9:0] expPrg(input logic [1:0] w);
    logic [7:0] inner;
    case (w)
      2'd0: inner = mSel[6] ? 8'hFE : mReg[6];
      2'd1: inner = mReg[7];
      2'd2: inner = mSel[6] ? mReg[6] : 8'hFE;
      default: inner = 8'hFF;
    endcase
    return {2'b00, inner & expMask(mSize[2:0])} | {1'b0, mPrgO, 1'b0};
  endfunction

  function automatic logic [7:0] expInner1k(input logic [12:0] a);
    logic [2:0] e;
    e = {a[12] ^ mSel[7], a[11:10]};
    if (e < 3'd4) return {mReg[e[1]][7:1], a[10]};
    return mReg[e - 3'd2];
  endfunction

  function automatic logic [12:0] expChr(input logic [12:0] a);
    if (mSize[5]) return {10'd0, expInner1k(a)[2:0]};
    return {5'd0, expInner1k(a)} | {2'b00, mChrO, 3'b000};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string ctx);
    for (int w = 0; w < 4; w++) begin
      cpuAddr = 16'h8000 | 16'(w << 13) | 16'($urandom_range(0, 16'h1FFF));
      #1;
      check({ctx, " R3/R4 prgBank"}, prgBank, expPrg(2'(w)));
      check({ctx, " R4 prgChip"}, prgChip, expPrg(2'(w)) >> 6);
    end
    for (int c = 0; c < 8; c++) begin
      ppuAddr = 13'(c << 10) | 13'($urandom_range(0, 1023));
      #1;
      check({ctx, " R5/R6/R7 chrBank"}, chrBank, expChr(ppuAddr));
      check({ctx, " R6/R7 chrChip"}, chrChip, mSize[5] ? 0 : (expChr(ppuAddr) >> 9));
    end
    check({ctx, " R7 chrRamSel"}, chrRamSel, mSize[5]);
    check({ctx, " R8 mirror"}, mirror, !mMir);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (a[15:14] == 2'b10) begin
      case ({a[13], a[0]})
        2'b00: mSel = d;
        2'b01: mReg[mSel[2:0]] = d;
        2'b10: mMir = d[0];
        default: ;
      endcase
    end
    else if (a == 16'h5FF0) mSize = d;
    else if (a == 16'h5FF1) mPrgO = d;
    else if (a == 16'h5FF2) mChrO = d;
  endtask

  initial begin
    #(20 * 190000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    mSel = 0; mSize = 8'h24; mPrgO = 8'd159; mChrO = 0; mMir = 0;
    for (int i = 0; i < 8; i++) mReg[i] = (i == 7) ? 8'd1 : 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checkAll("R10 reset");

    // R1: aliased addresses and the dead slot
    wr(16'h9FFE, 8'h47); checkAll("R1 alias select");
    wr(16'hB0F3, 8'h55); checkAll("R1 A13A0=11 ignored");
    wr(16'h8F01, 8'h9A); checkAll("R2 data reg7");
    wr(16'hBFFE, 8'h01); checkAll("R8 mirror set");

    // R11: undecoded writes
    wr(16'hC000, 8'hFF); wr(16'h5FF3, 8'hFF); wr(16'h7FF0, 8'h00);
    wr(16'hE001, 8'h13); wr(16'h4FF1, 8'h00);
    checkAll("R11 undecoded");

    // R9 / R4: every size-mask entry with ROM CHR
    wr(16'h5FF1, 8'h05); wr(16'h5FF2, 8'h2C);
    for (int s = 0; s < 8; s++) begin
      wr(16'h5FF0, 8'(s));
      checkAll("R9 size mode");
    end

    // R5: CHR inversion with every register loaded
    for (int r = 0; r < 8; r++) begin
      wr(16'h8000, 8'h80 | 8'(r));
      wr(16'h8001, 8'($urandom));
    end
    checkAll("R5 inverted");
    wr(16'h8000, 8'h40); checkAll("R3 swapped");
    wr(16'h5FF0, 8'h20); checkAll("R7 ram mode");

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      case ($urandom_range(0, 5))
        0: a = 16'h8000 | 16'($urandom_range(0, 16'h3FFF));
        1: a = 16'h8001 | 16'($urandom_range(0, 16'h3FFF));
        2: a = 16'h5FF0 + 16'($urandom_range(0, 3));
        3: a = 16'(($urandom_range(0, 16'h3FFF) << 1) | 1) | 16'h8000;
        4: a = 16'($urandom);
        default: a = 16'hA000 | 16'($urandom_range(0, 16'h1FFF));
      endcase
      wr(a, 8'($urandom));
      checkAll("R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule